// File: doc/BRIEF.md
# Power Button Controller with Hold-to-Off Override

This block sits between a mechanical power button and the power-management logic of a system. It filters the active-low button pin against contact bounce using a 1 ms timebase, then turns the clean button level into a status flag. Gated by an enable, that flag becomes an event request toward the interrupt logic, either SCI or SMI. A mode input decides whether the flag is raised as soon as a press is recognised or only once the button has been pressed and then let go.

A second path guards against a hung system. If the clean button level stays pressed for more than four seconds (4000 ticks) while the override enable is set, the block deasserts its active-low power-on output. It keeps that output deasserted until reset, whatever the button does afterwards. Software can clear the override enable to turn this path off. The status flag is cleared by writing 1 through a one-cycle clear strobe.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: After reset, `sts_o` is 0, `evt_req_o` is 0 and `pwr_on_n_o` is 0, which means power is on.
- R2: A new button level is accepted only after the synchronised pin shows that same level at two consecutive `tick_1ms` pulses. A level that lasts for a single tick changes nothing, and the accepted level changes only in the cycle after a tick.
- R3: When `press_only` is 0, recognising a press leaves `sts_o` at 0. `sts_o` becomes 1 once the matching release has been recognised, as long as power has not been cut.
- R4: When `press_only` is 1, `sts_o` becomes 1 as soon as a press is recognised, without waiting for the release.
- R5: If the debounced button stays pressed for 4000 ticks after it is recognised and `ovr_en` is 1, `pwr_on_n_o` goes to 1. After 3999 ticks it is still 0.
- R6: If the button is released before the hold limit is reached, `pwr_on_n_o` stays 0 and only the status flag reacts.
- R7: While `ovr_en` is 0, no hold length drives `pwr_on_n_o` to 1.
- R8: `evt_req_o` is 1 exactly when `sts_o` is 1 and `evt_en` is 1.
- R9: A one-cycle pulse on `sts_clr` clears `sts_o`, and `evt_req_o` falls with it. If a new status event arrives in the same cycle, the new event wins.
- R10: Once `pwr_on_n_o` is 1, it stays 1 until reset. No later status event is recorded, including the release that follows the power cut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Raw power-button pin, low while pressed, asynchronous |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| press_only | input | 1 | 1: event on press; 0: event on press-then-release |
| ovr_en | input | 1 | Enables the hold-to-power-off override |
| sts_clr | input | 1 | Write-1 strobe that clears the status flag |
| evt_en | input | 1 | Lets the status flag raise an event request |
| sts_o | output | 1 | Power-button status flag |
| evt_req_o | output | 1 | Event request toward SCI/SMI |
| pwr_on_n_o | output | 1 | Active-low power-on, 1 removes system power |

## Verification
A debouncer that accepts a level too early lets a one-tick glitch set `sts_o` once a second glitch tick follows. A debouncer that accepts too late delays the flag by a whole tick, so the bench samples the flag after each tick at the count where it must have just changed. An off-by-one in the hold counter shows at `pwr_on_n_o` at tick 3999 or tick 4001 instead of 4000. The bench probes both sides of that edge. A power-cut latch that releases, or a status path that ignores the cut, shows after the next release or press once power has been removed.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

    // Selects the moment at which a button event is recorded.
    typedef enum logic {
        EVT_ON_RELEASE = 1'b0,
        EVT_ON_PRESS   = 1'b1
    } evt_mode_e;

    // Debounced button edges, one cycle wide.
    typedef struct packed {
        logic pressed;
        logic released;
    } btn_edge_t;

endpackage

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce #(
    parameter int unsigned RUN_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic tick,
    output logic level_n_o
);
    localparam int unsigned RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN);

    typedef struct packed {
        logic [1:0]    sync;
        logic          samp;
        logic [RW-1:0] run;
        logic          level;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pin_n};
        if (tick) begin
            if (st_q.sync[1] == st_q.samp) begin
                if (st_q.run < RUN_MAX) begin
                    st_d.run = st_q.run + RW'(1);
                end
            end else begin
                st_d.run = RW'(1);
            end
            st_d.samp = st_q.sync[1];
            if (st_d.run == RUN_MAX) begin
                st_d.level = st_q.sync[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: 2'b11, samp: 1'b1, run: RUN_MAX, level: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_n_o = st_q.level;

endmodule

// File: rtl/pwrbtn_hold_timer.sv
module pwrbtn_hold_timer #(
    parameter int unsigned HOLD_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pressed,
    input  logic tick,
    output logic done_o
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pressed) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt < CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = (st_q.cnt == CNT_MAX);

endmodule

// File: rtl/pwrbtn_event.sv
module pwrbtn_event
    import pwrbtn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pressed,
    input  logic press_only,
    input  logic power_cut,
    input  logic sts_clr,
    input  logic evt_en,
    output logic sts_set_o,
    output logic sts_o,
    output logic evt_req_o
);
    typedef struct packed {
        logic prev;
        logic sts;
    } evt_t;

    evt_t      st_d, st_q;
    btn_edge_t edge_c;
    evt_mode_e mode_c;

    always_comb begin
        mode_c          = evt_mode_e'(press_only);
        edge_c.pressed  = pressed && !st_q.prev;
        edge_c.released = !pressed && st_q.prev;

        sts_set_o = 1'b0;
        if (!power_cut) begin
            if (mode_c == EVT_ON_PRESS) begin
                sts_set_o = edge_c.pressed;
            end else begin
                sts_set_o = edge_c.released;
            end
        end

        st_d      = st_q;
        st_d.prev = pressed;
        if (sts_set_o) begin
            st_d.sts = 1'b1;
        end else if (sts_clr) begin
            st_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b0, sts: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o     = st_q.sts;
    assign evt_req_o = st_q.sts && evt_en;

endmodule

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl #(
    parameter int unsigned DEB_RUN    = 2,
    parameter int unsigned HOLD_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic tick_1ms,
    input  logic press_only,
    input  logic ovr_en,
    input  logic sts_clr,
    input  logic evt_en,
    output logic sts_o,
    output logic evt_req_o,
    output logic pwr_on_n_o
);
    typedef struct packed {
        logic off;
    } ctl_t;

    ctl_t st_d, st_q;
    logic deb_level_n;
    logic btn_pressed;
    logic hold_done;
    logic sts_set;

    pwrbtn_debounce #(.RUN_LEN(DEB_RUN)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (btn_n),
        .tick      (tick_1ms),
        .level_n_o (deb_level_n)
    );

    assign btn_pressed = !deb_level_n;

    pwrbtn_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .pressed (btn_pressed),
        .tick    (tick_1ms),
        .done_o  (hold_done)
    );

    pwrbtn_event u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pressed    (btn_pressed),
        .press_only (press_only),
        .power_cut  (st_q.off),
        .sts_clr    (sts_clr),
        .evt_en     (evt_en),
        .sts_set_o  (sts_set),
        .sts_o      (sts_o),
        .evt_req_o  (evt_req_o)
    );

    always_comb begin
        st_d = st_q;
        if (hold_done && ovr_en) begin
            st_d.off = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{off: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_on_n_o = st_q.off;

endmodule

// File: rtl/pwrbtn_ctrl_chk.sv
module pwrbtn_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_1ms,
    input logic ovr_en,
    input logic sts_clr,
    input logic evt_en,
    input logic sts_o,
    input logic evt_req_o,
    input logic pwr_on_n_o,
    input logic deb_level_n,
    input logic hold_done,
    input logic sts_set
);
    // R2
    level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(deb_level_n) |-> $past(tick_1ms));

    // R5
    cut_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on_n_o) |-> $past(hold_done));

    // R7
    cut_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on_n_o) |-> $past(ovr_en));

    // R8
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_req_o |-> (evt_en && sts_o));

    // R9
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !sts_set) |=> !sts_o);

    // R10
    cut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_n_o |=> pwr_on_n_o);

    // R10
    no_status_after_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on_n_o && !sts_o) |=> !sts_o);
endmodule

bind pwrbtn_ctrl pwrbtn_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1ms    (tick_1ms),
    .ovr_en      (ovr_en),
    .sts_clr     (sts_clr),
    .evt_en      (evt_en),
    .sts_o       (sts_o),
    .evt_req_o   (evt_req_o),
    .pwr_on_n_o  (pwr_on_n_o),
    .deb_level_n (deb_level_n),
    .hold_done   (hold_done),
    .sts_set     (sts_set)
);

// File: tb/tb_pwrbtn_ctrl.sv
`timescale 1ns/1ps
module tb_pwrbtn_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic tick_1ms = 1'b0;
    logic press_only = 1'b0;
    logic ovr_en = 1'b1;
    logic sts_clr = 1'b0;
    logic evt_en = 1'b1;
    logic sts_o, evt_req_o, pwr_on_n_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwrbtn_ctrl dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .tick_1ms(tick_1ms),
        .press_only(press_only), .ovr_en(ovr_en), .sts_clr(sts_clr),
        .evt_en(evt_en), .sts_o(sts_o), .evt_req_o(evt_req_o),
        .pwr_on_n_o(pwr_on_n_o)
    );

    // vector: {clr, btn_n, ticks[15:0], exp_sts, exp_req, exp_pwr_n}
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'd2,   1'b0, 1'b0, 1'b0},  // R1 idle
        {1'b0, 1'b0, 16'd1,   1'b0, 1'b0, 1'b0},  // R2 one tick only
        {1'b0, 1'b1, 16'd2,   1'b0, 1'b0, 1'b0},  // R2 glitch ignored
        {1'b0, 1'b0, 16'd2,   1'b0, 1'b0, 1'b0},  // R3 press, no status yet
        {1'b0, 1'b1, 16'd2,   1'b1, 1'b1, 1'b0},  // R3 release sets status
        {1'b1, 1'b1, 16'd0,   1'b0, 1'b0, 1'b0},  // R9 clear
        {1'b0, 1'b0, 16'd102, 1'b0, 1'b0, 1'b0},  // R6 short hold
        {1'b0, 1'b1, 16'd2,   1'b1, 1'b1, 1'b0},  // R6 release, power on
        {1'b1, 1'b1, 16'd1,   1'b0, 1'b0, 1'b0}   // R9 clear again
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            @(negedge clk);
            tick_1ms = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        btn_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sts", sts_o, 1'b0);
        check("R1 req", evt_req_o, 1'b0);
        check("R1 pwr", pwr_on_n_o, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][20]) pulse_clr();
            btn_n = VEC[v][19];
            do_ticks(int'(VEC[v][18:3]));
            check($sformatf("R2/R3/R6/R9 vec%0d sts", v), sts_o, VEC[v][2]);
            check($sformatf("R8 vec%0d req", v), evt_req_o, VEC[v][1]);
            check($sformatf("R6 vec%0d pwr", v), pwr_on_n_o, VEC[v][0]);
        end

        // R8 gating by evt_en
        btn_n = 1'b0; do_ticks(2);
        btn_n = 1'b1; do_ticks(2);
        evt_en = 1'b0; @(negedge clk);
        check("R8 sts held", sts_o, 1'b1);
        check("R8 req masked", evt_req_o, 1'b0);
        evt_en = 1'b1; @(negedge clk);
        check("R8 req restored", evt_req_o, 1'b1);
        pulse_clr();

        // R4 press-only mode
        press_only = 1'b1;
        btn_n = 1'b0; do_ticks(1);
        check("R4 not yet", sts_o, 1'b0);
        do_ticks(1);
        check("R4 on press", sts_o, 1'b1);
        pulse_clr();
        btn_n = 1'b1; do_ticks(2);
        check("R4 no status on release", sts_o, 1'b0);
        press_only = 1'b0;

        // R9 set wins over clear in the same cycle
        btn_n = 1'b0; do_ticks(2);
        btn_n = 1'b1; do_ticks(1);
        tick_1ms = 1'b1; @(negedge clk); tick_1ms = 1'b0;
        sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 set wins", sts_o, 1'b1);
        pulse_clr();

        // R7 override disabled: long hold keeps power
        ovr_en = 1'b0;
        btn_n = 1'b0; do_ticks(2 + 4005);
        check("R7 power kept", pwr_on_n_o, 1'b0);
        btn_n = 1'b1; do_ticks(2);
        check("R7 release status", sts_o, 1'b1);
        check("R7 power still on", pwr_on_n_o, 1'b0);
        ovr_en = 1'b1;
        pulse_clr();

        // R5 hold boundary
        btn_n = 1'b0; do_ticks(2 + 3999);
        check("R5 at 3999", pwr_on_n_o, 1'b0);
        do_ticks(1);
        check("R5 at 4000", pwr_on_n_o, 1'b1);

        // R10 sticky cut, no status after cut
        btn_n = 1'b1; do_ticks(2);
        check("R10 release after cut", pwr_on_n_o, 1'b1);
        check("R10 no status", sts_o, 1'b0);
        press_only = 1'b1;
        btn_n = 1'b0; do_ticks(2);
        btn_n = 1'b1; do_ticks(2);
        check("R10 still off", pwr_on_n_o, 1'b1);
        check("R10 press ignored", sts_o, 1'b0);
        press_only = 1'b0;

        // R1 reset restores power
        do_reset();
        check("R1 pwr after reset", pwr_on_n_o, 1'b0);
        check("R1 sts after reset", sts_o, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule